// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Completion Polling

This block sits on the host side of a byte-wide parallel flash and carries out one alteration at a time: a byte program, a security-ID byte program, or a sector, block or chip erase. The host gives it one request with an operation type, a target address, a data byte, a polling-mode choice and a cycle budget. The block then masters a simple synchronous bus. It writes the unlock and command bytes, and then reads status at the target location until the flash reports that the operation has finished.

Completion can be detected in two ways. In toggle mode the block watches bit 6 until two back-to-back reads agree. In data mode it waits until bit 7 shows the final value. Near the end of the internal write a status read can return a mix of old and new bits. For that reason an apparent completion whose full byte does not match is not rejected at once. The same location is read twice more, and the block rejects the operation only if either of those reads is wrong. Security-ID programming always uses toggle mode. A cycle budget bounds the polling phase.

The bus is abstracted to single-cycle transfers. A write occurs in every cycle where `bus_wr` is high. In every cycle where `bus_rd` is high, the flash returns `bus_rdata` in that same cycle, and the block captures it at the closing clock edge.

Top module: `flash_op_poller`

## Requirements
- R1: `req_ready` is high exactly while the block is idle (also during and right after reset). A `req_valid` seen while busy is ignored and does not disturb the operation under way.
- R2: A byte program (op 0) writes four cycles, one per clock, starting the cycle after acceptance: (0xAAA,0xAA), (0x555,0x55), (0xAAA,0xA0), (target,data).
- R3: An erase writes six cycles: (0xAAA,0xAA), (0x555,0x55), (0xAAA,0x80), (0xAAA,0xAA), (0x555,0x55), then a final cycle. The final cycle is (target,0x50) for sector erase (op 1), (target,0x30) for block erase (op 2) and (0xAAA,0x10) for chip erase (op 3).
- R4: A security-ID program (op 4) writes (0xAAA,0xAA), (0x555,0x55), (0xAAA,0xA5), (target,data). It always polls in toggle mode, whatever `req_toggle` says. Op codes 5 to 7 act as op 0.
- R5: Status reads start in the cycle after the final write. They present the final write's address, which is 0xAAA for chip erase. No write happens during polling, and read and write are never high together.
- R6: In toggle mode (`req_toggle`=1) the first status read only records bit 6. A later read whose bit 6 equals that of the previous read is an apparent completion.
- R7: In data mode a read is an apparent completion when bit 7 equals bit 7 of the expected byte. The expected byte is the data byte for a program and 0xFF for an erase.
- R8: If the byte read at an apparent completion equals the expected byte, the block reports done. Otherwise it makes exactly two more reads. It reports done if both equal the expected byte, and fail otherwise.
- R9: `req_limit` is latched at acceptance and caps the number of polling-phase reads. When that many reads have been made without a result, the next cycle issues no read and the block reports timeout. A limit of 0 gives no read at all.
- R10: `op_done`, `op_fail` and `op_timeout` are one-cycle pulses, at most one at a time. The pulse appears in the cycle after the deciding cycle, and in that same cycle `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_op | input | 3 | 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 security-ID program |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | 1 selects toggle-mode polling, 0 data-mode |
| req_limit | input | TW | Maximum number of polling reads |
| req_ready | output | 1 | Idle, a request may be given |
| bus_wr | output | 1 | Bus write this cycle |
| bus_rd | output | 1 | Bus read this cycle |
| bus_addr | output | AW | Bus address, zero when the bus is unused |
| bus_wdata | output | 8 | Write data, zero when not writing |
| bus_rdata | input | 8 | Read data returned in the cycle of `bus_rd` |
| op_done | output | 1 | Operation finished correctly |
| op_fail | output | 1 | Re-reads rejected the completion |
| op_timeout | output | 1 | Polling budget exhausted |

## Verification
Some properties are checked on every cycle. Read and write never overlap. Status reads never exceed the latched budget, and consecutive reads keep one address. The sequencer index never runs past the last write of its operation. The three result pulses are exclusive and one cycle long, and the bus stays quiet while the block reports ready. Other behaviour only the scenarios can show: the exact command bytes and addresses for each operation, the forced toggle mode for security-ID programming, the choice between done and fail after the two re-reads, and the exact cycle of the timeout. The bench checks these by feeding chosen status sequences and comparing every output cycle by cycle against a behavioural model.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    OP_PROG       = 3'd0,
    OP_SECT_ERASE = 3'd1,
    OP_BLK_ERASE  = 3'd2,
    OP_CHIP_ERASE = 3'd3,
    OP_SECID_PROG = 3'd4
  } fop_e;

  typedef enum logic [1:0] {AS_HI, AS_LO, AS_TGT} asel_e;

  localparam logic [11:0] UNLOCK_HI = 12'hAAA;
  localparam logic [11:0] UNLOCK_LO = 12'h555;

  localparam logic [7:0] K_UNL1  = 8'hAA;
  localparam logic [7:0] K_UNL2  = 8'h55;
  localparam logic [7:0] K_PROG  = 8'hA0;
  localparam logic [7:0] K_SECID = 8'hA5;
  localparam logic [7:0] K_ERASE = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h50;
  localparam logic [7:0] K_BLK   = 8'h30;
  localparam logic [7:0] K_CHIP  = 8'h10;

  function automatic logic is_erase(fop_e op);
    return (op == OP_SECT_ERASE) || (op == OP_BLK_ERASE) || (op == OP_CHIP_ERASE);
  endfunction

  function automatic fop_e decode_op(logic [2:0] raw);
    return (raw > 3'd4) ? OP_PROG : fop_e'(raw);
  endfunction

  function automatic logic [2:0] seq_last(fop_e op);
    return is_erase(op) ? 3'd5 : 3'd3;
  endfunction

  function automatic logic [7:0] erase_code(fop_e op);
    case (op)
      OP_SECT_ERASE: return K_SECT;
      OP_BLK_ERASE:  return K_BLK;
      default:       return K_CHIP;
    endcase
  endfunction

  function automatic logic [7:0] seq_byte(fop_e op, logic [2:0] idx, logic [7:0] d);
    case (idx)
      3'd0:    return K_UNL1;
      3'd1:    return K_UNL2;
      3'd2:    return is_erase(op) ? K_ERASE : ((op == OP_SECID_PROG) ? K_SECID : K_PROG);
      3'd3:    return is_erase(op) ? K_UNL1 : d;
      3'd4:    return K_UNL2;
      3'd5:    return erase_code(op);
      default: return 8'h00;
    endcase
  endfunction

  function automatic asel_e seq_asel(fop_e op, logic [2:0] idx);
    if (idx == seq_last(op)) return AS_TGT;
    if (idx == 3'd1 || idx == 3'd4) return AS_LO;
    return AS_HI;
  endfunction

  function automatic logic [7:0] final_byte(fop_e op, logic [7:0] d);
    return is_erase(op) ? 8'hFF : d;
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_poll_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  fop_e          op,
  input  logic [AW-1:0] tgt,
  input  logic [7:0]    data,
  output logic          wr,
  output logic [AW-1:0] addr,
  output logic [7:0]    wdata,
  output logic          last
);

  localparam int PADW = AW - 12;

  logic [2:0] idx;
  asel_e      sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= 3'd0;
    else if (!active) idx <= 3'd0;
    else              idx <= idx + 3'd1;
  end

  always_comb begin
    sel   = seq_asel(op, idx);
    wr    = active;
    last  = active && (idx == seq_last(op));
    wdata = active ? seq_byte(op, idx, data) : 8'h00;
    addr  = '0;
    if (active) begin
      case (sel)
        AS_HI:   addr = {{PADW{1'b0}}, UNLOCK_HI};
        AS_LO:   addr = {{PADW{1'b0}}, UNLOCK_LO};
        default: addr = tgt;
      endcase
    end
  end

  // R2 R3: the step index never passes the final write of the operation
  p_seq_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= seq_last(op)));

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);

  // R9: a status read is only ever issued while budget remains
  p_read_within_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt < limit));

endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval (
  input  logic       toggle_mode,
  input  logic       first,
  input  logic [7:0] prev,
  input  logic [7:0] rdata,
  input  logic [7:0] expect_byte,
  output logic       apparent,
  output logic       exact
);

  function automatic logic toggle_settled(logic [7:0] a, logic [7:0] b);
    return a[6] == b[6];
  endfunction

  function automatic logic poll_bit_ok(logic [7:0] r, logic [7:0] e);
    return r[7] == e[7];
  endfunction

  always_comb begin
    exact = (rdata == expect_byte);
    if (toggle_mode) apparent = !first && toggle_settled(rdata, prev);
    else             apparent = poll_bit_ok(rdata, expect_byte);
  end

endmodule

// File: rtl/flash_op_poller.sv
module flash_op_poller
  import flash_poll_pkg::*;
#(
  parameter int AW = 21,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_toggle,
  input  logic [TW-1:0] req_limit,
  output logic          req_ready,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          op_done,
  output logic          op_fail,
  output logic          op_timeout
);

  localparam int PADW = AW - 12;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_CHK1, S_CHK2} st_e;

  st_e           st;
  fop_e          op_q;
  logic [AW-1:0] tgt_q;
  logic [7:0]    data_q;
  logic [7:0]    exp_q;
  logic [7:0]    prev_q;
  logic [TW-1:0] lim_q;
  logic          tog_q, first_q, ok1_q;
  logic          done_q, fail_q, to_q;

  // named internal events
  logic          accept;
  logic          in_poll;
  logic          expired;
  logic          seq_wr, seq_last;
  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_wdata;
  logic          apparent, exact;
  fop_e          op_in;

  assign op_in   = decode_op(req_op);
  assign accept  = req_valid && (st == S_IDLE);
  assign in_poll = (st == S_POLL) || (st == S_CHK1) || (st == S_CHK2);

  flash_cmd_seq #(.AW(AW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .active(st == S_CMD),
    .op    (op_q),
    .tgt   (tgt_q),
    .data  (data_q),
    .wr    (seq_wr),
    .addr  (seq_addr),
    .wdata (seq_wdata),
    .last  (seq_last)
  );

  flash_poll_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!in_poll),
    .tick   (bus_rd),
    .limit  (lim_q),
    .expired(expired)
  );

  flash_status_eval u_eval (
    .toggle_mode(tog_q),
    .first      (first_q),
    .prev       (prev_q),
    .rdata      (bus_rdata),
    .expect_byte(exp_q),
    .apparent   (apparent),
    .exact      (exact)
  );

  always_comb begin
    req_ready = (st == S_IDLE);
    bus_wr    = seq_wr;
    bus_wdata = seq_wdata;
    bus_rd    = in_poll && !expired;
    if (seq_wr)      bus_addr = seq_addr;
    else if (bus_rd) bus_addr = tgt_q;
    else             bus_addr = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_PROG;
      tgt_q   <= '0;
      data_q  <= 8'h00;
      exp_q   <= 8'h00;
      prev_q  <= 8'h00;
      lim_q   <= '0;
      tog_q   <= 1'b0;
      first_q <= 1'b0;
      ok1_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      to_q   <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= op_in;
          tgt_q  <= (op_in == OP_CHIP_ERASE) ? {{PADW{1'b0}}, UNLOCK_HI} : req_addr;
          data_q <= req_data;
          exp_q  <= final_byte(op_in, req_data);
          tog_q  <= req_toggle || (op_in == OP_SECID_PROG);
          lim_q  <= req_limit;
          st     <= S_CMD;
        end
        S_CMD: if (seq_last) begin
          first_q <= 1'b1;
          st      <= S_POLL;
        end
        S_POLL: begin
          if (expired) begin
            to_q <= 1'b1;
            st   <= S_IDLE;
          end else begin
            first_q <= 1'b0;
            prev_q  <= bus_rdata;
            if (apparent) begin
              if (exact) begin
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else begin
                st <= S_CHK1;
              end
            end
          end
        end
        S_CHK1: begin
          if (expired) begin
            to_q <= 1'b1;
            st   <= S_IDLE;
          end else begin
            ok1_q <= exact;
            st    <= S_CHK2;
          end
        end
        S_CHK2: begin
          if (expired) to_q <= 1'b1;
          else if (ok1_q && exact) done_q <= 1'b1;
          else fail_q <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign op_done    = done_q;
  assign op_fail    = fail_q;
  assign op_timeout = to_q;

  // R10: at most one result per cycle, each lasting a single cycle
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_done, op_fail, op_timeout}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  p_fail_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_fail |=> !op_fail);
  p_result_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done || op_fail || op_timeout) |-> req_ready);

  // R5: never read and write together; consecutive status reads keep one address
  p_no_rd_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  p_poll_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd)) |-> $stable(bus_addr));

  // R1: the bus is quiet while the block advertises readiness
  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_wr || bus_rd));

endmodule

// File: tb/flash_op_poller_test.sv
`timescale 1ns/1ps
module flash_op_poller_test;

  localparam int AW = 21;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          req_toggle = 1'b0;
  logic [TW-1:0] req_limit = '0;
  logic          req_ready, bus_wr, bus_rd, op_done, op_fail, op_timeout;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;

  flash_op_poller #(.AW(AW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
    .req_limit(req_limit), .req_ready(req_ready), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .op_done(op_done), .op_fail(op_fail),
    .op_timeout(op_timeout)
  );

  always #4 clk = ~clk;

  // flash stand-in: returns bytes from a scripted list, one per read
  logic [7:0] rdv [0:255];
  int rptr = 0;
  assign bus_rdata = rdv[rptr % 256];
  always @(posedge clk) if (rst_n && bus_rd) rptr <= rptr + 1;

  typedef struct {
    logic          wr, rd;
    logic [AW-1:0] addr;
    logic [7:0]    wd;
    logic          rdy, dn, fl, to;
    string         tag;
  } cyc_t;

  cyc_t expq[$];
  logic [7:0] rl[$];
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic cmp_en = 1'b0;

  function automatic cyc_t mk(logic wr, logic rd, logic [AW-1:0] a, logic [7:0] wd,
                              logic rdy, logic dn, logic fl, logic to, string tag);
    cyc_t c;
    c.wr = wr; c.rd = rd; c.addr = a; c.wd = wd;
    c.rdy = rdy; c.dn = dn; c.fl = fl; c.to = to; c.tag = tag;
    return c;
  endfunction

  always @(negedge clk) begin
    cyc_t e;
    logic [AW+13:0] act, ex;
    cycles++;
    if (cmp_en) begin
      if (expq.size() > 0) e = expq.pop_front();
      else e = mk(0, 0, '0, 8'h00, 1, 0, 0, 0, "R1");
      act = {bus_wr, bus_rd, bus_addr, bus_wdata, req_ready, op_done, op_fail, op_timeout};
      ex  = {e.wr, e.rd, e.addr, e.wd, e.rdy, e.dn, e.fl, e.to};
      compared++;
      if (act !== ex) begin
        mismatched++;
        $display("FAIL %s: got wr=%b rd=%b a=%h d=%h rdy=%b r=%b%b%b expected wr=%b rd=%b a=%h d=%h rdy=%b r=%b%b%b",
          e.tag, bus_wr, bus_rd, bus_addr, bus_wdata, req_ready, op_done, op_fail, op_timeout,
          e.wr, e.rd, e.addr, e.wd, e.rdy, e.dn, e.fl, e.to);
      end
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // behavioural model of one operation, then drive it
  task automatic run_op(int op, logic [AW-1:0] a, logic [7:0] d, logic tog, int lim, int poke_at);
    int eff_op, k, cnt, phase;
    logic erase, tmode, first, ok1, fin;
    logic [7:0] exp_b, prev, v, third;
    logic [AW-1:0] tgt;
    string wtag;
    int result;
    @(negedge clk); #1;
    for (int i = 0; i < rl.size(); i++) rdv[(rptr + i) % 256] = rl[i];
    eff_op = (op > 4) ? 0 : op;
    erase  = (eff_op >= 1 && eff_op <= 3);
    tgt    = (eff_op == 3) ? 21'h000AAA : a;
    exp_b  = erase ? 8'hFF : d;
    tmode  = tog || (eff_op == 4);
    wtag   = erase ? "R3" : ((eff_op == 4) ? "R4" : "R2");
    third  = erase ? 8'h80 : ((eff_op == 4) ? 8'hA5 : 8'hA0);
    expq.push_back(mk(1, 0, 21'h000AAA, 8'hAA, 0, 0, 0, 0, wtag));
    expq.push_back(mk(1, 0, 21'h000555, 8'h55, 0, 0, 0, 0, wtag));
    expq.push_back(mk(1, 0, 21'h000AAA, third, 0, 0, 0, 0, wtag));
    if (erase) begin
      expq.push_back(mk(1, 0, 21'h000AAA, 8'hAA, 0, 0, 0, 0, wtag));
      expq.push_back(mk(1, 0, 21'h000555, 8'h55, 0, 0, 0, 0, wtag));
      expq.push_back(mk(1, 0, tgt, (eff_op == 1) ? 8'h50 : ((eff_op == 2) ? 8'h30 : 8'h10), 0, 0, 0, 0, wtag));
    end else begin
      expq.push_back(mk(1, 0, tgt, d, 0, 0, 0, 0, wtag));
    end
    k = 0; cnt = 0; phase = 0; first = 1; ok1 = 0; prev = 0; result = 0; fin = 0;
    while (!fin) begin
      if (cnt == lim) begin
        expq.push_back(mk(0, 0, '0, 8'h00, 0, 0, 0, 0, "R9"));
        result = 3; fin = 1;
      end else begin
        expq.push_back(mk(0, 1, tgt, 8'h00, 0, 0, 0, 0, tmode ? "R6" : "R7"));
        v = rl[k]; k++; cnt++;
        if (phase == 0) begin
          logic hit;
          if (tmode) begin
            hit = !first && (v[6] == prev[6]);
            first = 0; prev = v;
          end else hit = (v[7] == exp_b[7]);
          if (hit) begin
            if (v == exp_b) begin result = 1; fin = 1; end
            else phase = 1;
          end
        end else if (phase == 1) begin
          ok1 = (v == exp_b); phase = 2;
        end else begin
          result = (ok1 && v == exp_b) ? 1 : 2; fin = 1;
        end
      end
    end
    expq.push_back(mk(0, 0, '0, 8'h00, 1, result == 1, result == 2, result == 3,
                      (result == 3) ? "R9" : ((phase == 2) ? "R8" : "R10")));
    req_valid = 1; req_op = op[2:0]; req_addr = a; req_data = d;
    req_toggle = tog; req_limit = lim[TW-1:0];
    @(posedge clk); #1;
    req_valid = 0;
    if (poke_at > 0) begin
      repeat (poke_at) @(posedge clk);
      #1;
      // R1: a request while busy must leave the running sequence untouched
      req_valid = 1; req_op = 3'd3; req_addr = 21'h1FFFFF; req_data = 8'h00; req_limit = 1;
      @(posedge clk); #1;
      req_valid = 0;
    end
    while (expq.size() > 0) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    rl.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rdv[i] = 8'h00;
    repeat (3) @(negedge clk);
    compared++;
    if (req_ready !== 1'b1 || bus_wr !== 1'b0 || bus_rd !== 1'b0 || op_done !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset: got rdy=%b wr=%b rd=%b expected 1 0 0", req_ready, bus_wr, bus_rd);
    end
    rst_n = 1'b1;
    @(negedge clk); #1;
    cmp_en = 1'b1;

    // R2 R7: program, data mode, two busy reads then true data
    rl = '{8'h80, 8'hC4, 8'h3C};
    run_op(0, 21'h012345, 8'h3C, 0, 50, 0);
    // R2 R6: program, toggle mode
    rl = '{8'h40, 8'h00, 8'h40, 8'h5A};
    run_op(0, 21'h00F00F, 8'h5A, 1, 50, 0);
    // R3 R7: sector erase, data mode
    rl = '{8'h00, 8'h40, 8'hFF};
    run_op(1, 21'h003000, 8'h00, 0, 50, 0);
    // R3 R6: block erase, toggle mode
    rl = '{8'h40, 8'h00, 8'hFF, 8'hFF};
    run_op(2, 21'h1F0000, 8'h00, 1, 50, 0);
    // R3 R5: chip erase polls at the final command address
    rl = '{8'h00, 8'h00, 8'hFF};
    run_op(3, 21'h054321, 8'h00, 0, 50, 0);
    // R4: security-ID program forces toggle mode despite req_toggle=0
    rl = '{8'h40, 8'h00, 8'h11};
    run_op(4, 21'h000010, 8'h11, 0, 50, 0);
    // R4: undefined op code behaves as program
    rl = '{8'h22};
    run_op(6, 21'h000020, 8'h22, 0, 50, 0);
    // R8: apparent completion with wrong byte, both re-reads good
    rl = '{8'h01, 8'h85, 8'h81, 8'h81};
    run_op(0, 21'h000100, 8'h81, 0, 50, 0);
    // R8: one re-read wrong gives a reject
    rl = '{8'h85, 8'h81, 8'h84};
    run_op(0, 21'h000200, 8'h81, 0, 50, 0);
    // R9: endless toggling runs out a budget of 3
    rl = '{8'h40, 8'h00, 8'h40, 8'h00};
    run_op(0, 21'h000300, 8'h77, 1, 3, 0);
    // R9: budget of zero gives no read at all
    rl = '{8'h77};
    run_op(0, 21'h000301, 8'h77, 1, 0, 0);
    // R9: budget runs out during the re-reads
    rl = '{8'h85, 8'h81, 8'h81};
    run_op(0, 21'h000302, 8'h81, 0, 2, 0);
    // R1: request poked while writing and while polling
    rl = '{8'h80, 8'h80, 8'h80, 8'h00};
    run_op(0, 21'h000400, 8'h00, 0, 50, 2);
    rl = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
    run_op(1, 21'h005000, 8'h00, 0, 50, 8);
    // R10: back-to-back operations after a pulse
    rl = '{8'hAB};
    run_op(0, 21'h000500, 8'hAB, 0, 50, 0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule